// File: doc/BRIEF.md
# Write-then-read burst segmenter

This block runs one serial-flash style command made of W outgoing bytes followed by R incoming bytes, using a shift engine that moves at most 32 bits per transfer. The command is cut into rounds of up to four bytes. Each round is filled with outgoing bytes first, and any room left over is filled with incoming bytes, so a single round can carry both directions. The outgoing bytes of a round are packed against the round's active length rather than a fixed word edge. The sequencer then programs the engine, starts it, polls it until it finishes, and unpacks the incoming bytes from the receive word.

The host side gives the two counts and a start pulse. It then feeds outgoing bytes over a valid/ready stream. Incoming bytes come back one per cycle on a valid-qualified output. When the command is over, `done` pulses for one cycle, and `error` is high in that same cycle if a round timed out. The sequencer also handles the framing around the rounds: it clears stale status, enables both directions, asserts chip select before the first round and releases it at the end. It reaches the engine through a small register port:

- address 0: control
- address 1: status
- address 2: transmit word
- address 3: receive word

Top module: `burst_segmenter`

## Requirements
- R1: In every round, the write share is min(remaining writes, 4) and the read share is min(remaining reads, 4 − write share). Both remaining counts drop by those shares. The round's length is 8 × (write share + read share) bits, and that length minus one is written to control bits [4:0]. Example: 6 writes and 5 reads give the rounds 4W+0R, 2W+2R and 0W+3R.
- R2: The rounds stop at the first round whose length would be zero. A command with both counts zero starts no round but is still framed and still ends with `done`.
- R3: Write byte i of a round sits at bit offset 8 × (n − 1 − i) of the transmit word, where n is the round's total byte count. All other bits are zero.
- R4: Read byte i of a round is taken from bit offset 8 × (read share − 1 − i) of the receive word. Bytes leave on `rd_data` in command order.
- R5: After `start`, the first engine accesses are made in this order. First, a write of 1 to status bit 0 (ready), which clears stale status. Second, a control write with transmit enable (bit 8) and receive enable (bit 9) set and chip select (bit 10) clear. Third, a control write with bits 8, 9 and 10 set.
- R6: Each round is run in this order:
  - write the transmit word;
  - write control with the length;
  - write control again with go (bit 11) added;
  - read status until bit 0 (ready) is 1 and bit 1 (busy) is 0;
  - clear ready by writing 1 to status bit 0.

  Every go write carries chip select and both enables.
- R7: If a round's completion is not seen within POLL_LIMIT status reads (default 10000), the command aborts. The receive word is not read, no bytes of that round are emitted, and `error` is high with `done`.
- R8: After the last round, or after an abort, chip select is released by a control write with bit 10 clear. `done` then pulses for exactly one cycle.
- R9: `wr_ready` is high only while a round is still collecting its write bytes. No transmit word is written until all of that round's write bytes have been accepted, however slowly they arrive.
- R10: A round's incoming bytes are emitted on consecutive cycles, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle command start, taken while idle |
| wr_count | input | CNT_W | Number of outgoing bytes |
| rd_count | input | CNT_W | Number of incoming bytes |
| wr_valid | input | 1 | Outgoing byte valid |
| wr_data | input | 8 | Outgoing byte |
| wr_ready | output | 1 | Outgoing byte accepted when high with wr_valid |
| rd_valid | output | 1 | Incoming byte valid |
| rd_data | output | 8 | Incoming byte |
| done | output | 1 | One-cycle end-of-command pulse |
| error | output | 1 | High with done when a round timed out |
| reg_we | output | 1 | Engine register write strobe |
| reg_re | output | 1 | Engine register read strobe |
| reg_addr | output | 2 | Engine register address |
| reg_wdata | output | 32 | Engine register write data |
| reg_rdata | input | 32 | Engine register read data, valid in the cycle of reg_re |

## Verification
Several properties are checked on every cycle by the assertions:
- every go write carries chip select;
- `done` never lasts two cycles, and `error` appears only with `done`;
- `wr_ready` is not withdrawn before a byte is accepted;
- the poll counter stays below its limit;
- once a round starts emitting, its bytes run on consecutive cycles;
- the engine port never reads and writes in the same cycle.

Other behaviour only the bench's scenarios can show: how rounds are split for mixed, write-only, read-only and empty commands; the packed word and the unpacked byte order; the start order of clear, enable and select; the stall on slow write data; and the exact count of status reads before a timeout.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_TXD  = 2'd2;
  localparam logic [1:0] A_RXD  = 2'd3;

  localparam int B_TXEN = 8;
  localparam int B_RXEN = 9;
  localparam int B_CS   = 10;
  localparam int B_GO   = 11;
  localparam int B_RDY  = 0;
  localparam int B_BSY  = 1;

  localparam int MAX_BYTES = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_EN, S_CSON, S_PLAN, S_FILL, S_TXD, S_LEN,
    S_GO, S_POLL, S_ACK, S_RXD, S_EMIT, S_CSOFF, S_DONE
  } seg_state_e;
endpackage

// File: rtl/seg_round_plan.sv
module seg_round_plan #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] rem_w,
  input  logic [CNT_W-1:0] rem_r,
  output logic [2:0]       take_w,
  output logic [2:0]       take_r,
  output logic [2:0]       take_n
);
  logic [2:0] room;

  always_comb begin
    if (rem_w >= CNT_W'(4)) take_w = 3'd4;
    else                    take_w = rem_w[2:0];
    room = 3'd4 - take_w;
    if (rem_r >= CNT_W'(room)) take_r = room;
    else                       take_r = rem_r[2:0];
    take_n = take_w + take_r;
  end
endmodule

// File: rtl/seg_tx_pack.sv
module seg_tx_pack #(
  parameter int NB = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        push,
  input  logic [7:0]  din,
  input  logic [2:0]  need,
  input  logic [2:0]  total,
  output logic        full,
  output logic [31:0] word
);
  logic [7:0] bytes_q [NB];
  logic [2:0] cnt_q, cnt_d;

  assign full = (cnt_q == need);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = 3'd0;
    else if (push) cnt_d = cnt_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 3'd0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NB; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      bytes_q[g] <= 8'd0;
      else if (push && !clr && cnt_q == 3'(g))         bytes_q[g] <= din;
    end
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < int'(need))
        word = word | ({24'd0, bytes_q[i]} << (8 * (int'(total) - 1 - i)));
    end
  end
endmodule

// File: rtl/seg_rx_unpack.sv
module seg_rx_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [2:0]  count,
  output logic        valid,
  output logic        last,
  output logic [7:0]  data
);
  logic [31:0] word_q;
  logic [2:0]  left_q, left_d;
  logic [31:0] shifted;

  assign valid = (left_q != 3'd0);
  assign last  = (left_q == 3'd1);

  always_comb begin
    left_d = left_q;
    if (load)       left_d = count;
    else if (valid) left_d = left_q - 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= 3'd0;
      word_q <= '0;
    end else begin
      left_q <= left_d;
      if (load) word_q <= word;
    end
  end

  always_comb begin
    shifted = '0;
    if (valid) shifted = word_q >> (8 * (int'(left_q) - 1));
    data = shifted[7:0];
  end

  // R10
  burst_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last && !load) |=> valid);
endmodule

// File: rtl/burst_segmenter.sv
module burst_segmenter
  import seg_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int POLL_LIMIT = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [CNT_W-1:0] rd_count,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             error,
  output logic             reg_we,
  output logic             reg_re,
  output logic [1:0]       reg_addr,
  output logic [31:0]      reg_wdata,
  input  logic [31:0]      reg_rdata
);
  localparam int PC_W = $clog2(POLL_LIMIT + 1);

  seg_state_e  state_q, state_d;
  logic [CNT_W-1:0] rem_w_q, rem_w_d, rem_r_q, rem_r_d;
  logic [2:0]  tw_q, tw_d, tr_q, tr_d, tn_q, tn_d;
  logic [PC_W-1:0] poll_q, poll_d;
  logic        tout_q, tout_d;

  logic [2:0]  p_w, p_r, p_n;
  logic        pk_clr, pk_push, pk_full;
  logic [31:0] pk_word;
  logic        up_load, up_valid, up_last;
  logic [5:0]  bits;
  logic [31:0] en_word, cs_word;

  seg_round_plan #(.CNT_W(CNT_W)) u_plan (
    .rem_w(rem_w_q), .rem_r(rem_r_q),
    .take_w(p_w), .take_r(p_r), .take_n(p_n)
  );

  seg_tx_pack #(.NB(MAX_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .push(pk_push), .din(wr_data),
    .need(tw_q), .total(tn_q), .full(pk_full), .word(pk_word)
  );

  seg_rx_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .load(up_load), .word(reg_rdata),
    .count(tr_q), .valid(up_valid), .last(up_last), .data(rd_data)
  );

  assign bits    = {tn_q, 3'b000} - 6'd1;
  assign en_word = (32'd1 << B_TXEN) | (32'd1 << B_RXEN);
  assign cs_word = en_word | (32'd1 << B_CS);

  assign wr_ready = (state_q == S_FILL) && !pk_full;
  assign pk_push  = wr_ready && wr_valid;
  assign rd_valid = up_valid;
  assign done     = (state_q == S_DONE);
  assign error    = done && tout_q;

  always_comb begin
    state_d = state_q;
    rem_w_d = rem_w_q;
    rem_r_d = rem_r_q;
    tw_d    = tw_q;
    tr_d    = tr_q;
    tn_d    = tn_q;
    poll_d  = poll_q;
    tout_d  = tout_q;
    pk_clr  = 1'b0;
    up_load = 1'b0;
    reg_we  = 1'b0;
    reg_re  = 1'b0;
    reg_addr  = A_CTRL;
    reg_wdata = '0;
    case (state_q)
      S_IDLE: if (start) begin
        rem_w_d = wr_count;
        rem_r_d = rd_count;
        tout_d  = 1'b0;
        state_d = S_CLR;
      end
      S_CLR: begin
        reg_we = 1'b1; reg_addr = A_STAT; reg_wdata = 32'd1 << B_RDY;
        state_d = S_EN;
      end
      S_EN: begin
        reg_we = 1'b1; reg_wdata = en_word;
        state_d = S_CSON;
      end
      S_CSON: begin
        reg_we = 1'b1; reg_wdata = cs_word;
        state_d = S_PLAN;
      end
      S_PLAN: begin
        if (p_n == 3'd0) state_d = S_CSOFF;
        else begin
          tw_d = p_w; tr_d = p_r; tn_d = p_n;
          rem_w_d = rem_w_q - CNT_W'(p_w);
          rem_r_d = rem_r_q - CNT_W'(p_r);
          pk_clr  = 1'b1;
          state_d = S_FILL;
        end
      end
      S_FILL: if (pk_full) state_d = S_TXD;
      S_TXD: begin
        reg_we = 1'b1; reg_addr = A_TXD; reg_wdata = pk_word;
        state_d = S_LEN;
      end
      S_LEN: begin
        reg_we = 1'b1; reg_wdata = cs_word | {27'd0, bits[4:0]};
        state_d = S_GO;
      end
      S_GO: begin
        reg_we = 1'b1;
        reg_wdata = cs_word | (32'd1 << B_GO) | {27'd0, bits[4:0]};
        poll_d = '0;
        state_d = S_POLL;
      end
      S_POLL: begin
        reg_re = 1'b1; reg_addr = A_STAT;
        if (reg_rdata[B_RDY] && !reg_rdata[B_BSY]) state_d = S_ACK;
        else if (poll_q == PC_W'(POLL_LIMIT - 1)) begin
          tout_d = 1'b1;
          state_d = S_ACK;
        end else poll_d = poll_q + PC_W'(1);
      end
      S_ACK: begin
        reg_we = 1'b1; reg_addr = A_STAT; reg_wdata = 32'd1 << B_RDY;
        if (tout_q)              state_d = S_CSOFF;
        else if (tr_q != 3'd0)   state_d = S_RXD;
        else                     state_d = S_PLAN;
      end
      S_RXD: begin
        reg_re = 1'b1; reg_addr = A_RXD;
        up_load = 1'b1;
        state_d = S_EMIT;
      end
      S_EMIT: if (up_last) state_d = S_PLAN;
      S_CSOFF: begin
        reg_we = 1'b1; reg_wdata = '0;
        state_d = S_DONE;
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rem_w_q <= '0;
      rem_r_q <= '0;
      tw_q    <= 3'd0;
      tr_q    <= 3'd0;
      tn_q    <= 3'd0;
      poll_q  <= '0;
      tout_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_w_q <= rem_w_d;
      rem_r_q <= rem_r_d;
      tw_q    <= tw_d;
      tr_q    <= tr_d;
      tn_q    <= tn_d;
      poll_q  <= poll_d;
      tout_q  <= tout_d;
    end
  end

  // R6
  go_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CTRL && reg_wdata[B_GO]) |-> reg_wdata[B_CS]);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q < PC_W'(POLL_LIMIT));
  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> wr_ready);
  // R6
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
endmodule

// File: tb/sim_burst_segmenter.sv
module sim_burst_segmenter;
  localparam int CLK_T = 10;
  localparam int CNT_W = 16;
  localparam int PLIM  = 10000;

  logic clk, rst_n, start, wr_valid, wr_ready, rd_valid, done, error;
  logic [CNT_W-1:0] wr_count, rd_count;
  logic [7:0]  wr_data, rd_data;
  logic        reg_we, reg_re;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  burst_segmenter #(.CNT_W(CNT_W), .POLL_LIMIT(PLIM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_count(wr_count),
    .rd_count(rd_count), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .error(error), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int checks = 0, fails = 0;
  initial clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // engine model
  logic        hang;
  logic        e_busy, e_rdy;
  int          e_cnt, rn;
  logic [31:0] e_rx;

  function automatic logic [31:0] pat(input int r);
    return {8'h40 + 8'(r), 8'h30 + 8'(r), 8'h20 + 8'(r), 8'h10 + 8'(r)};
  endfunction

  always_comb begin
    case (reg_addr)
      2'd1:    reg_rdata = {30'd0, e_busy, e_rdy};
      2'd3:    reg_rdata = e_rx;
      default: reg_rdata = 32'd0;
    endcase
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_busy <= 1'b0; e_rdy <= 1'b0; e_cnt <= 0; e_rx <= '0;
    end else begin
      if (reg_we && reg_addr == 2'd1 && reg_wdata[0]) e_rdy <= 1'b0;
      if (reg_we && reg_addr == 2'd0 && reg_wdata[11]) begin
        e_busy <= 1'b1; e_cnt <= 3;
        e_rx <= pat(rn + 1);
      end else if (e_busy && !hang) begin
        if (e_cnt == 1) begin e_busy <= 1'b0; e_rdy <= 1'b1; end
        e_cnt <= e_cnt - 1;
      end
      if (reg_we && reg_addr == 2'd0 && reg_wdata[11]) rn <= rn + 1;
    end
  end

  // scoreboard state
  logic [31:0] txq[$];
  logic [4:0]  lenq[$];
  int          cumq[$];
  logic [7:0]  rxq[$];
  int  ph, acc, gos, exp_gos, polls, exp_polls, cs_st;
  bit  exp_err, done_seen;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid && wr_ready) acc++;
      if (reg_re && reg_addr == 2'd1) polls++;
      if (reg_we) begin
        if (ph == 0) begin
          check(reg_addr == 2'd1 && reg_wdata[0], "R5 status clear first", reg_addr, 1);
          ph = 1;
        end else if (ph == 1) begin
          check(reg_addr == 2'd0 && reg_wdata[10:8] == 3'b011, "R5 enable second", reg_wdata, 32'h300);
          ph = 2;
        end else if (ph == 2) begin
          check(reg_addr == 2'd0 && reg_wdata[10:8] == 3'b111, "R5 select third", reg_wdata, 32'h700);
          ph = 3;
        end
        if (reg_addr == 2'd0) cs_st = int'(reg_wdata[10]);
        if (reg_addr == 2'd2) begin
          if (txq.size() == 0) check(0, "R2 unexpected round", 0, 1);
          else begin
            logic [31:0] ew; int ec;
            ew = txq.pop_front(); ec = cumq.pop_front();
            check(reg_wdata == ew, "R3 tx word", reg_wdata, ew);
            check(acc == ec, "R9 bytes before tx word", acc, ec);
          end
        end
        if (reg_addr == 2'd0 && reg_wdata[11]) begin
          gos++; polls = 0;
          check(reg_wdata[10:8] == 3'b111, "R6 go with select", reg_wdata[10:8], 7);
          if (lenq.size() != 0) begin
            logic [4:0] el;
            el = lenq.pop_front();
            check(reg_wdata[4:0] == el, "R1 round length", reg_wdata[4:0], el);
          end
        end
      end
      if (rd_valid) begin
        if (rxq.size() == 0) check(0, "R7 unexpected rx byte", rd_data, 0);
        else begin
          logic [7:0] eb;
          eb = rxq.pop_front();
          check(rd_data == eb, "R4 R10 rx byte", rd_data, eb);
        end
      end
      if (done) begin
        check(cs_st == 0, "R8 select released", cs_st, 0);
        check(gos == exp_gos, "R1 R2 round count", gos, exp_gos);
        check(rxq.size() == 0 && txq.size() == 0, "R4 all bytes seen", rxq.size(), 0);
        check(error == exp_err, "R7 error flag", error, exp_err);
        if (exp_err) check(polls == exp_polls, "R7 poll count", polls, exp_polls);
        done_seen = 1;
      end
    end
  end

  task automatic run_cmd(input int w, input int r, input int gap, input bit hg);
    int rw, rr, cum, bi, rnd;
    logic [7:0] wb[$];
    for (int k = 0; k < w; k++) wb.push_back(8'(8'hA0 + k * 7));
    rw = w; rr = r; cum = 0; bi = 0; rnd = 0;
    exp_gos = 0;
    while (1) begin
      int tw, tr, n;
      logic [31:0] word;
      tw = (rw < 4) ? rw : 4;
      tr = (rr < 4 - tw) ? rr : 4 - tw;
      n = tw + tr;
      if (n == 0) break;
      rw -= tw; rr -= tr; rnd++;
      word = 0;
      for (int i = 0; i < tw; i++) word |= {24'd0, wb[bi + i]} << (8 * (n - 1 - i));
      bi += tw; cum += tw;
      txq.push_back(word); cumq.push_back(cum); lenq.push_back(5'(8 * n - 1));
      exp_gos++;
      if (!hg) for (int i = 0; i < tr; i++) rxq.push_back(8'(8'h10 * (tr - i) + rnd));
      if (hg) break;
    end
    exp_err = hg; exp_polls = PLIM;
    gos = 0; acc = 0; ph = 0; done_seen = 0;
    @(posedge clk); #1;
    hang = hg; rn = 0;
    wr_count = CNT_W'(w); rd_count = CNT_W'(r); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    for (int k = 0; k < w; k++) begin
      repeat (gap) @(posedge clk);
      #1; wr_valid = 1'b1; wr_data = wb[k];
      do @(negedge clk); while (!wr_ready);
      @(posedge clk); #1; wr_valid = 1'b0;
    end
    wait (done_seen);
    repeat (3) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_T * 190000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_valid = 1'b0; wr_data = 8'd0;
    wr_count = '0; rd_count = '0; hang = 1'b0; rn = 0; ph = 3; cs_st = 0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);
    check(!done && !rd_valid && !wr_ready && !reg_we && !reg_re, "R8 reset outputs quiet",
          {done, rd_valid, wr_ready, reg_we, reg_re}, 0);
    run_cmd(6, 5, 0, 0);   // R1 R3 R4 mixed rounds
    run_cmd(3, 0, 4, 0);   // R9 slow write data
    run_cmd(0, 9, 0, 0);   // R4 R10 read-only
    run_cmd(0, 0, 0, 0);   // R2 empty command
    run_cmd(1, 7, 2, 0);   // R1 mixed first round
    run_cmd(9, 2, 1, 0);   // R3 write spill into third round
    run_cmd(2, 1, 0, 1);   // R7 engine never completes
    finish_run();
  end
endmodule